// File: doc/BRIEF.md
# Prioritized DMA Channel Arbiter with Linking

This block decides which of several DMA channels may drive the single shared bus master. Each channel presents a request, and while the bus is idle the lowest-numbered requesting channel wins. The winner holds the grant until its release condition arrives. A channel set to steal cycles gives the bus back after one transfer. A channel in continuous mode keeps it until its byte count is exhausted or an error is reported. The data movement itself happens elsewhere: this block only arbitrates and sequences.

When a granted channel releases, it can trigger another channel according to its own link setting. One target can be triggered after every single cycle-steal transfer, and another when the count runs out. The trigger is a one-cycle internal request. It is ORed with the target's external request in the idle cycle that always follows a release, so a chain of channels runs without any processor involvement.

Top module: `dma_link_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `grant` and `link_req` become all zeros.
- R2: `grant` never has more than one bit set.
- R3: When `grant` is zero, the next cycle's grant is the lowest-numbered bit of `chan_req | link_req`, with channel 0 the highest priority.
- R4: When `grant` is zero and no external or link request is present, `grant` stays zero.
- R5: A granted channel with `chan_greedy` low releases (grant zero next cycle) on its `xfer_done` pulse.
- R6: A granted channel holds its grant, even against higher-priority requests, until a release event; for a channel with `chan_greedy` high, `xfer_done` is not a release event.
- R7: `count_zero` or `xfer_err` of the granted channel releases it in the next cycle, whatever its mode.
- R8: Link mode 2'b00 (bits [2c+1:2c] of `link_mode` for channel c) never produces a link request.
- R9: Link mode 2'b01 pulses `link_req` for target A (bits [2c+1:2c] of `link_tgt_a`) after a cycle-steal `xfer_done`, and for target B (same bits of `link_tgt_b`) on `count_zero`, one cycle after the event.
- R10: Link mode 2'b10 pulses target A after a cycle-steal `xfer_done` only; `count_zero` gives no link.
- R11: Link mode 2'b11 pulses target A on `count_zero` only; `xfer_done` gives no link.
- R12: A channel may link to itself; the pulse re-requests it and it is granted again in the following cycle.
- R13: `xfer_done`, `count_zero` and `xfer_err` of a channel that is not granted change neither `grant` nor `link_req`.
- R14: An `xfer_err` of the granted channel suppresses every link request from that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req | input | NCH | External request per channel |
| chan_greedy | input | NCH | 1: continuous mode, 0: one transfer per grant |
| link_mode | input | 2*NCH | Link mode per channel, 2 bits each |
| link_tgt_a | input | 2*NCH | First link target per channel |
| link_tgt_b | input | 2*NCH | Second link target per channel |
| xfer_done | input | NCH | One-cycle pulse: a single transfer finished |
| count_zero | input | NCH | One-cycle pulse: byte count reached zero |
| xfer_err | input | NCH | One-cycle pulse: transfer error |
| grant | output | NCH | One-hot bus grant, registered |
| link_req | output | NCH | One-cycle internal link requests, registered |

## Verification
A new grant appears one clock after the idle cycle in which the request is seen. A release shows as a zero grant one clock after the event pulse. A link pulse appears together with that zero grant, and the linked channel's grant follows one clock later. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It compares both outputs at every falling edge, so each result is checked in exactly the cycle it is due. Directed points confirm those latencies explicitly.

// File: rtl/dla_pkg.sv
// Shared types for the DMA link arbiter.
package dla_pkg;
    // Link mode code per channel; the encoding is decoded by dla_link_gen.
    typedef enum logic [1:0] {
        LNK_OFF  = 2'b00,  // no linking
        LNK_BOTH = 2'b01,  // target A per steal transfer, target B at count end
        LNK_EACH = 2'b10,  // target A per steal transfer
        LNK_END  = 2'b11   // target A at count end
    } link_mode_e;
endpackage

// File: rtl/dla_prio_pick.sv
// Fixed-priority picker: one-hot of the lowest-numbered set request bit.
// Assumes bit 0 is the highest priority; all-zero input gives all-zero output.
module dla_prio_pick #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] pick
);
    // Scan from the lowest priority upward so the last hit is the winner.
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dla_link_gen.sv
// Link request generator: decodes the granted channel's link mode and
// events into a vector of target requests for the next cycle.
// Assumes grant is one-hot or zero; an error on the granted channel
// suppresses every link it would otherwise raise.
module dla_link_gen
    import dla_pkg::*;
#(
    parameter int NCH = 4,
    parameter int IDW = 2
) (
    input  logic [NCH-1:0]     grant,
    input  logic [NCH-1:0]     steal_done,
    input  logic [NCH-1:0]     cnt_end,
    input  logic [NCH-1:0]     err,
    input  logic [2*NCH-1:0]   mode,
    input  logic [IDW*NCH-1:0] tgt_a,
    input  logic [IDW*NCH-1:0] tgt_b,
    output logic [NCH-1:0]     link_d
);
    logic [NCH-1:0] fire_a;
    logic [NCH-1:0] fire_b;

    // Per-channel decision whether target A or target B is requested.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        link_mode_e m;
        logic       live;
        assign m    = link_mode_e'(mode[2*c +: 2]);
        assign live = grant[c] && !err[c];
        assign fire_a[c] = live &&
            ((steal_done[c] && (m == LNK_BOTH || m == LNK_EACH)) ||
             (cnt_end[c] && m == LNK_END));
        assign fire_b[c] = live && cnt_end[c] && (m == LNK_BOTH);
    end

    // Scatter the fired channels' targets into the request vector.
    always_comb begin
        link_d = '0;
        for (int c = 0; c < NCH; c++) begin
            if (fire_a[c]) link_d[tgt_a[c*IDW +: IDW]] = 1'b1;
            if (fire_b[c]) link_d[tgt_b[c*IDW +: IDW]] = 1'b1;
        end
    end
endmodule

// File: rtl/dma_link_arbiter.sv
// Fixed-priority bus arbiter for DMA channels with per-channel linking.
// Grants the lowest-numbered pending channel while idle, holds the grant
// until the owner's release event, then passes through one idle cycle in
// which link pulses from the release join the external requests.
// Assumes event pulses are one cycle long; events of channels that do not
// hold the grant are ignored.
module dma_link_arbiter #(
    parameter int NCH = 4,
    localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       chan_req,
    input  logic [NCH-1:0]       chan_greedy,
    input  logic [2*NCH-1:0]     link_mode,
    input  logic [IDW*NCH-1:0]   link_tgt_a,
    input  logic [IDW*NCH-1:0]   link_tgt_b,
    input  logic [NCH-1:0]       xfer_done,
    input  logic [NCH-1:0]       count_zero,
    input  logic [NCH-1:0]       xfer_err,
    output logic [NCH-1:0]       grant,
    output logic [NCH-1:0]       link_req
);
    logic [NCH-1:0] grant_q, grant_d;
    logic [NCH-1:0] link_q, link_d;
    logic [NCH-1:0] steal_done;
    logic [NCH-1:0] winner;
    logic           busy;
    logic           release_ev;

    // A completed transfer only ends the tenure in cycle-steal mode.
    assign steal_done = xfer_done & ~chan_greedy;
    assign busy       = |grant_q;
    assign release_ev = |(grant_q & (steal_done | count_zero | xfer_err));

    dla_prio_pick #(.NCH(NCH)) u_pick (
        .req  (chan_req | link_q),
        .pick (winner)
    );

    dla_link_gen #(.NCH(NCH), .IDW(IDW)) u_link (
        .grant      (grant_q),
        .steal_done (steal_done),
        .cnt_end    (count_zero),
        .err        (xfer_err),
        .mode       (link_mode),
        .tgt_a      (link_tgt_a),
        .tgt_b      (link_tgt_b),
        .link_d     (link_d)
    );

    // Next grant: hold, release to idle, or arbitrate from idle.
    always_comb begin
        if (busy) grant_d = release_ev ? '0 : grant_q;
        else      grant_d = winner;
    end

    // Grant and link pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            link_q  <= '0;
        end else begin
            grant_q <= grant_d;
            link_q  <= link_d;
        end
    end

    assign grant    = grant_q;
    assign link_req = link_q;
endmodule

// File: rtl/dla_checker.sv
// Assertion checker for dma_link_arbiter, attached by bind below.
module dla_checker #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   chan_req,
    input logic [NCH-1:0]   chan_greedy,
    input logic [2*NCH-1:0] link_mode,
    input logic [NCH-1:0]   xfer_done,
    input logic [NCH-1:0]   count_zero,
    input logic [NCH-1:0]   xfer_err,
    input logic [NCH-1:0]   grant,
    input logic [NCH-1:0]   link_req
);
    logic [NCH-1:0] eff;
    logic [NCH-1:0] lowest;
    logic           rel_any;
    assign eff     = chan_req | link_req;
    assign lowest  = eff & (~eff + 1'b1);
    assign rel_any = |(grant & ((xfer_done & ~chan_greedy) | count_zero | xfer_err));

    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_idle_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && eff != '0) |=> grant == $past(lowest));

    p_idle_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && eff == '0) |=> grant == '0);

    p_steal_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & xfer_done & ~chan_greedy)) |=> grant == '0);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !rel_any) |=> $stable(grant));

    p_end_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & (count_zero | xfer_err))) |=> grant == '0);

    // Link pulses only follow a release and last one cycle (R9, R12).
    p_link_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req != '0) |-> (grant == '0));

    p_link_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req != '0) |=> link_req == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[c] && link_mode[2*c +: 2] == 2'b00) |=> link_req == '0);

        p_err_nolink_r14: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[c] && xfer_err[c]) |=> link_req == '0);
    end
endmodule

bind dma_link_arbiter dla_checker #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_req    (chan_req),
    .chan_greedy (chan_greedy),
    .link_mode   (link_mode),
    .xfer_done   (xfer_done),
    .count_zero  (count_zero),
    .xfer_err    (xfer_err),
    .grant       (grant),
    .link_req    (link_req)
);

// File: tb/test_dma_link_arbiter.sv
`timescale 1ns/1ps
module test_dma_link_arbiter;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan_req = '0, chan_greedy = '0;
    logic [7:0] link_mode = '0, link_tgt_a = '0, link_tgt_b = '0;
    logic [3:0] xfer_done = '0, count_zero = '0, xfer_err = '0;
    logic [3:0] grant, link_req;

    int    total = 0;
    int    bad = 0;
    bit    checking = 0;
    bit    finished = 0;
    string cur = "R1";

    // Reference model state.
    int       m_g = -1;
    logic [3:0] m_link = '0;

    always #4 clk = ~clk;

    dma_link_arbiter #(.NCH(NCH)) i_dma_link_arbiter (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_greedy(chan_greedy),
        .link_mode(link_mode), .link_tgt_a(link_tgt_a), .link_tgt_b(link_tgt_b),
        .xfer_done(xfer_done), .count_zero(count_zero), .xfer_err(xfer_err),
        .grant(grant), .link_req(link_req)
    );

    // Behavioural model stepped on the rising edge.
    always @(posedge clk) begin
        logic [3:0] nl;
        logic [3:0] eff;
        int         g;
        int         md;
        bit         rel;
        nl = '0;
        if (!rst_n) begin
            m_g = -1;
        end else if (m_g >= 0) begin
            g = m_g;
            md = int'(link_mode[g*2 +: 2]);
            rel = 0;
            if (xfer_err[g]) rel = 1;
            else begin
                if (xfer_done[g] && !chan_greedy[g]) begin
                    rel = 1;
                    if (md == 1 || md == 2) nl[link_tgt_a[g*2 +: 2]] = 1'b1;
                end
                if (count_zero[g]) begin
                    rel = 1;
                    if (md == 1) nl[link_tgt_b[g*2 +: 2]] = 1'b1;
                    if (md == 3) nl[link_tgt_a[g*2 +: 2]] = 1'b1;
                end
            end
            if (rel) m_g = -1;
        end else begin
            eff = chan_req | m_link;
            m_g = -1;
            for (int i = 3; i >= 0; i--) if (eff[i]) m_g = i;
        end
        m_link = rst_n ? nl : 4'b0000;
    end

    function automatic logic [3:0] exp_grant();
        return (m_g < 0) ? 4'b0000 : (4'b0001 << m_g);
    endfunction

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (checking) begin
            total++;
            if (grant !== exp_grant() || link_req !== m_link) begin
                bad++;
                $display("FAIL %s cycle-compare: grant=%b link=%b expected grant=%b link=%b",
                         cur, grant, link_req, exp_grant(), m_link);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [3:0] g_exp, logic [3:0] l_exp);
        total++;
        if (grant !== g_exp || link_req !== l_exp) begin
            bad++;
            $display("FAIL %s: grant=%b link=%b expected grant=%b link=%b",
                     tag, grant, link_req, g_exp, l_exp);
        end
    endtask

    task automatic pulse_done(int c);
        xfer_done[c] = 1'b1; step(); xfer_done[c] = 1'b0;
    endtask

    task automatic pulse_cz(int c);
        count_zero[c] = 1'b1; step(); count_zero[c] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 20000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        chk("R1", 4'b0000, 4'b0000);
        checking = 1;
        rst_n = 1'b1;
        step();

        // R3: lowest-numbered request wins from idle; R5: steal release.
        cur = "R3";
        chan_req = 4'b1010; step();
        chk("R3", 4'b0010, 4'b0000);
        cur = "R5";
        chan_req = 4'b0000; pulse_done(1);
        chk("R5", 4'b0000, 4'b0000);
        cur = "R4";
        step();
        chk("R4", 4'b0000, 4'b0000);

        // R6: greedy holds against higher priority; R7: count end releases.
        cur = "R6";
        chan_greedy = 4'b0100; chan_req = 4'b0100; step();
        chk("R6", 4'b0100, 4'b0000);
        chan_req = 4'b0101; pulse_done(2);
        chk("R6", 4'b0100, 4'b0000);
        step();
        chk("R6", 4'b0100, 4'b0000);
        cur = "R7";
        chan_req = 4'b0001; pulse_cz(2);
        chk("R7", 4'b0000, 4'b0000);
        step();
        chk("R3", 4'b0001, 4'b0000);
        chan_req = 4'b0000; pulse_done(0);
        chan_greedy = '0;
        step();

        // R9: mode 01, target A=2 per transfer, target B=3 at count end.
        cur = "R9";
        link_mode[1:0] = 2'b01; link_tgt_a[1:0] = 2'd2; link_tgt_b[1:0] = 2'd3;
        chan_req = 4'b0001; step();
        chan_req = 4'b0000; pulse_done(0);
        chk("R9", 4'b0000, 4'b0100);
        step();
        chk("R9", 4'b0100, 4'b0000);
        pulse_done(2); step();
        chan_req = 4'b0001; step();
        chan_req = 4'b0000; pulse_cz(0);
        chk("R9", 4'b0000, 4'b1000);
        step();
        chk("R9", 4'b1000, 4'b0000);
        pulse_done(3); step();

        // R10: mode 10, count end alone gives no link.
        cur = "R10";
        link_mode[1:0] = 2'b10; link_tgt_a[1:0] = 2'd1;
        chan_req = 4'b0001; step();
        chan_req = 4'b0000; pulse_cz(0);
        chk("R10", 4'b0000, 4'b0000);
        chan_req = 4'b0001; step();
        chan_req = 4'b0000; pulse_done(0);
        chk("R10", 4'b0000, 4'b0010);
        step();
        pulse_done(1); step();

        // R11: mode 11, single transfer gives no link, count end does.
        cur = "R11";
        link_mode[1:0] = 2'b11; link_tgt_a[1:0] = 2'd2;
        chan_req = 4'b0001; step();
        chan_req = 4'b0000; pulse_done(0);
        chk("R11", 4'b0000, 4'b0000);
        chan_req = 4'b0001; step();
        chan_req = 4'b0000; pulse_cz(0);
        chk("R11", 4'b0000, 4'b0100);
        step();
        pulse_done(2); step();

        // R8: mode 00 with both events at once.
        cur = "R8";
        link_mode[1:0] = 2'b00;
        chan_req = 4'b0001; step();
        chan_req = 4'b0000;
        xfer_done[0] = 1'b1; count_zero[0] = 1'b1; step();
        xfer_done[0] = 1'b0; count_zero[0] = 1'b0;
        chk("R8", 4'b0000, 4'b0000);
        step();

        // R12: channel 3 links to itself.
        cur = "R12";
        link_mode[7:6] = 2'b10; link_tgt_a[7:6] = 2'd3;
        chan_req = 4'b1000; step();
        chan_req = 4'b0000; pulse_done(3);
        chk("R12", 4'b0000, 4'b1000);
        step();
        chk("R12", 4'b1000, 4'b0000);
        link_mode[7:6] = 2'b00; pulse_done(3); step();

        // R13: events on an ungranted channel are ignored.
        cur = "R13";
        link_mode[5:4] = 2'b01; link_tgt_a[5:4] = 2'd0; link_tgt_b[5:4] = 2'd0;
        chan_req = 4'b0010; step();
        chan_req = 4'b0000;
        xfer_done[2] = 1'b1; count_zero[2] = 1'b1; xfer_err[2] = 1'b1; step();
        xfer_done[2] = 1'b0; count_zero[2] = 1'b0; xfer_err[2] = 1'b0;
        chk("R13", 4'b0010, 4'b0000);
        step();
        chk("R13", 4'b0010, 4'b0000);
        pulse_done(1); step();

        // R14: error together with link events suppresses all links.
        cur = "R14";
        link_mode[1:0] = 2'b01; link_tgt_a[1:0] = 2'd1; link_tgt_b[1:0] = 2'd2;
        chan_req = 4'b0001; step();
        chan_req = 4'b0000;
        xfer_done[0] = 1'b1; count_zero[0] = 1'b1; xfer_err[0] = 1'b1; step();
        xfer_done[0] = 1'b0; count_zero[0] = 1'b0; xfer_err[0] = 1'b0;
        chk("R14", 4'b0000, 4'b0000);
        step();

        // R2: random traffic checked against the model every cycle.
        cur = "R2";
        for (int n = 0; n < 600; n++) begin
            chan_req    = 4'($urandom);
            chan_greedy = 4'($urandom);
            link_mode   = 8'($urandom);
            link_tgt_a  = 8'($urandom);
            link_tgt_b  = 8'($urandom);
            xfer_done   = 4'($urandom);
            count_zero  = 4'($urandom) & 4'($urandom);
            xfer_err    = 4'($urandom) & 4'($urandom) & 4'($urandom);
            step();
            total++;
            if ($countones(grant) > 1) begin
                bad++;
                $display("FAIL R2: grant=%b expected at most one bit set", grant);
            end
        end

        checking = 0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule